// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port. It has one control register, one transmit buffer and one receive buffer. Two control bits select the operating mode. Mode 0 is a synchronous 8-bit shift register: the data line carries the bits in both directions and the clock line carries the shift clock. The other three modes are asynchronous frames of 10 or 11 bits. In the 11-bit frames, the ninth data bit is taken from a control bit when sending and written back to a control bit when receiving.

Bit timing comes from one of two sources. Mode 0 and mode 2 derive it from the block clock, which plays the role of the oscillator. Modes 1 and 3 derive it from an external overflow pulse input. A rate-doubling input, which belongs to a separate power-control register, changes the timing in every mode except mode 0. The port sets a transmit-done flag and a receive-done flag, and software clears both by writing the control register. The receiver samples at sixteen times the bit rate, votes on three samples taken near the middle of each bit, and discards false starts. It can also filter frames on their ninth bit.

Top module: `sport4`

## Requirements
- R1: After reset the control register reads 0x00 and the receive buffer reads 0x00. The clock line and the data output are high, and the data-line drive enable is low.
- R2: The control register reads back the value last written. The bit layout is: bit 7:6 = mode (0 shift, 1 ten-bit frame with pulse timing, 2 eleven-bit frame with clock timing, 3 eleven-bit frame with pulse timing), bit 5 = address filter, bit 4 = receive enable, bit 3 = ninth transmit bit, bit 2 = ninth receive bit, bit 1 = transmit done, bit 0 = receive done. When hardware sets a flag in the same cycle as a software write, the hardware set takes effect.
- R3: In mode 0, a write to the transmit buffer shifts 8 bits out, least significant bit first, on `rxd_out` while `rxd_oe` is high. `txd_out` carries the shift clock: low for the first half of each bit and high for the second half. Each bit lasts M0_DIV clock cycles.
- R4: In mode 0, with receive enable set, receive done clear and the transmitter idle, the port drives 8 shift clocks. On each rising edge it samples `rxd_in`, least significant bit first. It then loads the receive buffer and sets receive done, and it leaves the ninth receive bit unchanged.
- R5: Mode 1 sends a 0 start bit, 8 data bits (least significant first) and a 1 stop bit. One bit lasts 32 overflow pulses, or 16 pulses when the doubling input is high.
- R6: Modes 2 and 3 send start, 8 data bits, the ninth transmit bit and a stop bit. In mode 2 one bit lasts M2_DIV clock cycles, or half that when doubling is high. Mode 3 uses the pulse timing of R5.
- R7: A transmit-buffer write starts a frame, and transmit done is set when the last bit has been sent.
- R8: An asynchronous receiver that is enabled loads each complete frame into the receive buffer and sets receive done. The ninth receive bit gets the stop bit in mode 1 and the ninth data bit in modes 2 and 3.
- R9: A start bit that is no longer low at its middle is abandoned. No flag is set, and the next valid frame is still received.
- R10: In modes 2 and 3 with the address filter set, a frame whose ninth bit is 0 leaves the buffer and receive done untouched. A frame whose ninth bit is 1 is loaded.
- R11: While receive done is set, an incoming frame does not change the receive buffer.
- R12: With receive enable clear, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the oscillator reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| dbl_rate | input | 1 | Rate-doubling bit from the power-control register |
| ovf_pulse | input | 1 | External overflow pulse, one cycle wide |
| tx_wr | input | 1 | Transmit-buffer write strobe; starts a frame |
| tx_byte | input | 8 | Byte to send |
| rx_byte | output | 8 | Receive buffer |
| rxd_in | input | 1 | Data line input |
| rxd_out | output | 1 | Data line output value in mode 0 |
| rxd_oe | output | 1 | Data line drive enable (mode 0 transmit) |
| txd_out | output | 1 | Serial output, or shift clock in mode 0 |

## Verification
The bench loops the serial output back into the receiver. A table of frames runs through that loop, covering every mode, both settings of the doubling input, both values of the ninth bit, and data patterns that alternate, cluster and sit at the byte edges. Each transmitted bit is sampled at the middle of its cell, which separates frame length, bit order and bit period from one another. The received byte and ninth bit show whether the stop bit or the ninth data bit was captured. Directed runs then feed mode-0 reception from the bench, a short low glitch, a frame the address filter should reject followed by one it should accept, a frame that arrives while receive done is still set, and a frame sent with receive enable clear.

// File: rtl/sport4_pkg.sv
package sport4_pkg;
  typedef enum logic [1:0] {
    M_SHIFT   = 2'd0,
    M_ASYNC10 = 2'd1,
    M_FIXED11 = 2'd2,
    M_ASYNC11 = 2'd3
  } sp_mode_e;
endpackage

// File: rtl/sport4_rate.sv
module sport4_rate
  import sport4_pkg::*;
#(
  parameter int M0_DIV = 12,
  parameter int M2_DIV = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     smod,
  input  logic     ovf,
  output logic     s16_tick,
  output logic     m0_half
);
  localparam int HALF0   = M0_DIV / 2;
  localparam int PRE2    = M2_DIV / 16;
  localparam int CNT_MAX = (HALF0 > PRE2) ? HALF0 : PRE2;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          ph_q, ph_d, wrap;

  always_comb begin
    if (mode == M_SHIFT)  lim = CW'(HALF0 - 1);
    else if (smod)        lim = CW'(PRE2 / 2 - 1);
    else                  lim = CW'(PRE2 - 1);
    wrap  = (cnt_q >= lim);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    ph_d  = ph_q;
    if (ovf && !smod) ph_d = ~ph_q;
    m0_half = (mode == M_SHIFT) && wrap;
    case (mode)
      M_FIXED11:            s16_tick = wrap;
      M_ASYNC10, M_ASYNC11: s16_tick = ovf && (smod || ph_q);
      default:              s16_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  AST_M2_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FIXED11 && s16_tick) |=> (!s16_tick || mode != M_FIXED11)); // R6
endmodule

// File: rtl/sport4_tx.sv
module sport4_tx
  import sport4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sp_mode_e   mode,
  input  logic       tb8,
  input  logic       s16_tick,
  input  logic       m0_half,
  input  logic       start,
  input  logic [7:0] din,
  output logic       busy,
  output logic       line,
  output logic       sclk,
  output logic       done
);
  logic [10:0] sh_q, sh_d;
  logic [3:0]  sub_q, sub_d, bcnt_q, bcnt_d, last;
  logic        busy_q, busy_d, step, bit_end;

  always_comb begin
    step    = (mode == M_SHIFT) ? m0_half : s16_tick;
    last    = (mode == M_SHIFT) ? 4'd7 : ((mode == M_ASYNC10) ? 4'd9 : 4'd10);
    bit_end = step && ((mode == M_SHIFT) ? sub_q[0] : (sub_q == 4'hF));
    sh_d    = sh_q;
    sub_d   = sub_q;
    bcnt_d  = bcnt_q;
    busy_d  = busy_q;
    done    = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      sub_d  = '0;
      bcnt_d = '0;
      if (mode == M_SHIFT) sh_d = {3'b111, din};
      else                 sh_d = {1'b1, (mode == M_ASYNC10) ? 1'b1 : tb8, din, 1'b0};
    end else if (busy_q && step) begin
      sub_d = sub_q + 1'b1;
      if (bit_end) begin
        sh_d   = {1'b1, sh_q[10:1]};
        bcnt_d = bcnt_q + 1'b1;
        if (bcnt_q == last) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      sub_q  <= '0;
      bcnt_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      bcnt_q <= bcnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;
  assign sclk = busy_q ? sub_q[0] : 1'b1;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode != M_SHIFT) |=> (line == 1'b0)); // R5
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7
endmodule

// File: rtl/sport4_rx.sv
module sport4_rx
  import sport4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sp_mode_e   mode,
  input  logic       ren,
  input  logic       ri,
  input  logic       sm2,
  input  logic       tx_busy,
  input  logic       s16_tick,
  input  logic       m0_half,
  input  logic       rxd,
  output logic       busy,
  output logic       sclk,
  output logic       load,
  output logic [7:0] ld_data,
  output logic       ld_b8
);
  logic [1:0] sy_q, vote_q, vote_d;
  logic [8:0] sh_q, sh_d;
  logic [3:0] sub_q, sub_d, bcnt_q, bcnt_d, last;
  logic       busy_q, busy_d, rxs, maj, nine;

  always_comb begin
    rxs     = sy_q[1];
    maj     = (vote_q[1] & vote_q[0]) | (rxs & (vote_q[1] | vote_q[0]));
    nine    = (mode == M_FIXED11) || (mode == M_ASYNC11);
    last    = nine ? 4'd10 : 4'd9;
    ld_data = nine ? sh_q[7:0] : sh_q[8:1];
    ld_b8   = 1'b0;
    load    = 1'b0;
    sh_d    = sh_q;
    sub_d   = sub_q;
    bcnt_d  = bcnt_q;
    vote_d  = vote_q;
    busy_d  = busy_q;
    if (mode == M_SHIFT) begin
      if (!busy_q) begin
        if (ren && !ri && !tx_busy) begin
          busy_d = 1'b1;
          sub_d  = '0;
          bcnt_d = '0;
        end
      end else if (m0_half) begin
        sub_d = sub_q + 1'b1;
        if (!sub_q[0]) sh_d = {rxs, sh_q[8:1]};
        else begin
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == 4'd7) begin
            busy_d = 1'b0;
            load   = 1'b1;
          end
        end
      end
    end else begin
      if (!busy_q) begin
        if (ren && s16_tick && !rxs) begin
          busy_d = 1'b1;
          sub_d  = '0;
          bcnt_d = '0;
        end
      end else if (s16_tick) begin
        sub_d = sub_q + 1'b1;
        if (sub_q == 4'hF) bcnt_d = bcnt_q + 1'b1;
        if (sub_q == 4'd7 || sub_q == 4'd8) vote_d = {vote_q[0], rxs};
        if (sub_q == 4'd9) begin
          if (bcnt_q == 4'd0) begin
            if (maj) busy_d = 1'b0;
          end else if (bcnt_q == last) begin
            busy_d = 1'b0;
            ld_b8  = nine ? sh_q[8] : maj;
            load   = !ri && !(sm2 && nine && !sh_q[8]);
          end else begin
            sh_d = {maj, sh_q[8:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q   <= 2'b11;
      vote_q <= 2'b11;
      sh_q   <= '0;
      sub_q  <= '0;
      bcnt_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sy_q   <= {sy_q[0], rxd};
      vote_q <= vote_d;
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      bcnt_q <= bcnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign sclk = (busy_q && mode == M_SHIFT) ? sub_q[0] : 1'b1;

  AST_RX_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren && !busy_q) |=> !busy_q); // R12
endmodule

// File: rtl/sport4.sv
module sport4
  import sport4_pkg::*;
#(
  parameter int M0_DIV = 12,
  parameter int M2_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       dbl_rate,
  input  logic       ovf_pulse,
  input  logic       tx_wr,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       txd_out
);
  logic [7:0] ctl_q, ctl_d, rbuf_q, rbuf_d, rx_ld_data;
  logic       s16_tick, m0_half, tx_busy, tx_line, tx_sclk, tx_done;
  logic       rx_busy, rx_sclk, rx_load, rx_b8;
  sp_mode_e   mode;

  assign mode = sp_mode_e'(ctl_q[7:6]);

  sport4_rate #(.M0_DIV(M0_DIV), .M2_DIV(M2_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .smod(dbl_rate), .ovf(ovf_pulse),
    .s16_tick(s16_tick), .m0_half(m0_half));

  sport4_tx u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tb8(ctl_q[3]), .s16_tick(s16_tick),
    .m0_half(m0_half), .start(tx_wr), .din(tx_byte), .busy(tx_busy),
    .line(tx_line), .sclk(tx_sclk), .done(tx_done));

  sport4_rx u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ren(ctl_q[4]), .ri(ctl_q[0]),
    .sm2(ctl_q[5]), .tx_busy(tx_busy), .s16_tick(s16_tick), .m0_half(m0_half),
    .rxd(rxd_in), .busy(rx_busy), .sclk(rx_sclk), .load(rx_load),
    .ld_data(rx_ld_data), .ld_b8(rx_b8));

  always_comb begin
    ctl_d  = cfg_wr ? cfg_wdata : ctl_q;
    rbuf_d = rbuf_q;
    if (tx_done) ctl_d[1] = 1'b1;
    if (rx_load) begin
      ctl_d[0] = 1'b1;
      if (mode != M_SHIFT) ctl_d[2] = rx_b8;
      rbuf_d = rx_ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rbuf_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign cfg_rdata = ctl_q;
  assign rx_byte   = rbuf_q;
  assign rxd_oe    = (mode == M_SHIFT) && tx_busy;
  assign rxd_out   = rxd_oe ? tx_line : 1'b1;
  assign txd_out   = (mode != M_SHIFT) ? tx_line : (tx_busy ? tx_sclk : rx_sclk);

  AST_TI_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ctl_q[1]); // R7
  AST_RI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !cfg_wr) |=> $stable(rbuf_q)); // R11
  AST_RB8_M0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SHIFT && !cfg_wr) |=> $stable(ctl_q[2])); // R4
endmodule

// File: tb/tb_sport4.sv
`timescale 1ns/1ps
module tb_sport4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       dbl_rate = 1'b0;
  logic       ovf_pulse = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte;
  logic       rxd_out, rxd_oe, txd_out;
  logic       loop = 1'b0;
  logic       rx_drv = 1'b1;
  int         checks = 0;
  int         errors = 0;

  // each entry: mode[11:10], dbl[9], ninth bit[8], data[7:0]
  localparam logic [11:0] VEC [7] = '{
    {2'd1, 1'b0, 1'b0, 8'hA5}, {2'd1, 1'b1, 1'b0, 8'h3C},
    {2'd2, 1'b0, 1'b1, 8'h81}, {2'd2, 1'b1, 1'b0, 8'h5E},
    {2'd3, 1'b1, 1'b1, 8'hF0}, {2'd3, 1'b0, 1'b0, 8'h0F},
    {2'd0, 1'b0, 1'b0, 8'hC6}};

  always #2 clk = ~clk;
  always @(negedge clk) ovf_pulse <= ~ovf_pulse;

  sport4 dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dbl_rate(dbl_rate), .ovf_pulse(ovf_pulse),
    .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .rxd_in(loop ? txd_out : rx_drv), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .txd_out(txd_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_byte = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_bit(input int idx, input int maxc);
    for (int n = 0; n < maxc && !cfg_rdata[idx]; n++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctl in reset", cfg_rdata, 8'h00);
    chk("R1 line in reset", {rxd_oe, rxd_out, txd_out}, 3'b011);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl after reset", cfg_rdata, 8'h00);
    chk("R1 rx buffer after reset", rx_byte, 8'h00);

    for (int v = 0; v < 7; v++) begin
      automatic logic [1:0]  md  = VEC[v][11:10];
      automatic logic        tb8 = VEC[v][8];
      automatic logic [7:0]  d   = VEC[v][7:0];
      automatic logic [7:0]  cv  = {md, 1'b0, (md != 2'd0), tb8, 3'b000};
      automatic int          bt  = VEC[v][9] ? 32 : 64;
      automatic int          nb  = (md == 2'd1) ? 10 : 11;
      automatic logic [10:0] fr  = {1'b1, (md == 2'd1) ? 1'b1 : tb8, d, 1'b0};
      dbl_rate = VEC[v][9];
      loop = (md != 2'd0);
      cfg(cv);
      chk("R2 control readback", cfg_rdata, cv);
      send(d);
      if (md == 2'd0) begin
        realtime tprev = 0.0;
        for (int i = 0; i < 8; i++) begin
          @(posedge txd_out);
          if (i > 0) chk("R3 shift clock period ns", int'($realtime - tprev), 48);
          tprev = $realtime;
          @(negedge clk);
          chk("R3 shift data bit", {rxd_oe, rxd_out}, {1'b1, d[i]});
        end
        wait_bit(1, 100);
        chk("R7 TI after mode 0 send", cfg_rdata[1], 1'b1);
      end else begin
        repeat (bt / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
          chk((md == 2'd1) ? "R5 ten-bit frame bit" : "R6 eleven-bit frame bit", txd_out, fr[i]);
          repeat (bt) @(negedge clk);
        end
        wait_bit(1, 2 * bt);
        chk("R7 TI after frame", cfg_rdata[1], 1'b1);
        wait_bit(0, 2 * bt);
        chk("R8 RI on loopback", cfg_rdata[0], 1'b1);
        chk("R8 received byte", rx_byte, d);
        chk("R8 ninth receive bit", cfg_rdata[2], (md == 2'd1) ? 1'b1 : tb8);
      end
    end

    // R4: mode 0 reception driven by the bench
    loop = 1'b0;
    begin
      automatic logic [7:0] d = 8'h9B;
      rx_drv = d[0];
      cfg(8'h14);
      for (int i = 0; i < 8; i++) begin
        rx_drv = d[i];
        @(posedge txd_out);
        @(negedge clk);
      end
      wait_bit(0, 100);
      chk("R4 mode 0 receive flags", cfg_rdata, 8'h15);
      chk("R4 mode 0 received byte", rx_byte, d);
    end
    rx_drv = 1'b1;

    // R10: address filter on ninth bit
    dbl_rate = 1'b1;
    loop = 1'b1;
    cfg(8'hF0);
    send(8'h77);
    repeat (450) @(negedge clk);
    chk("R10 filtered frame RI", cfg_rdata[0], 1'b0);
    chk("R10 filtered frame buffer", rx_byte, 8'h9B);
    cfg(8'hF8);
    send(8'h66);
    wait_bit(0, 600);
    chk("R10 accepted frame RI", cfg_rdata[0], 1'b1);
    chk("R10 accepted frame buffer", rx_byte, 8'h66);

    // R11: RI still set, frame must not overwrite
    repeat (20) @(negedge clk);
    send(8'h11);
    repeat (500) @(negedge clk);
    chk("R11 buffer kept while RI set", rx_byte, 8'h66);
    chk("R11 RI still set", cfg_rdata[0], 1'b1);

    // R12: receiver disabled
    cfg(8'h40);
    send(8'h22);
    repeat (500) @(negedge clk);
    chk("R12 no RI when disabled", cfg_rdata[0], 1'b0);
    chk("R12 buffer unchanged when disabled", rx_byte, 8'h66);

    // R9: false start then recovery
    loop = 1'b0;
    cfg(8'h90);
    rx_drv = 1'b0;
    repeat (6) @(negedge clk);
    rx_drv = 1'b1;
    repeat (600) @(negedge clk);
    chk("R9 glitch sets no RI", cfg_rdata[0], 1'b0);
    chk("R9 glitch leaves buffer", rx_byte, 8'h66);
    loop = 1'b1;
    send(8'h3A);
    wait_bit(0, 600);
    chk("R9 recovery RI", cfg_rdata[0], 1'b1);
    chk("R9 recovery byte", rx_byte, 8'h3A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule